// File: doc/BRIEF.md
# Transactional Cache-Line Footprint Tracker

This block records which lines of a set-associative first-level data directory a running transaction has read or written. Every line slot has a valid bit, a transactional-read bit and a transactional-dirty bit. Every row also has one extension bit. The extension bit stands in, imprecisely, for read-tracked lines that have left the row. The block watches five streams: line fills, load executions, store writebacks, evictions and incoming coherency cross-interrogates (XIs). For each XI it decides in the same cycle whether to answer with a reject or to abort the transaction.

A conflicting exclusive or demote XI is rejected at first, which gives the transaction time to finish. A counter of back-to-back rejects caps this at a parameterised limit, so two cores cannot livelock on each other. A read-only XI cannot be rejected; when it touches the read footprint the transaction aborts. On commit the dirty marks and the extension bits are cleared. On abort every transactionally dirty line is invalidated in one cycle, which discards the speculative data. The directory is read through a lookup port that returns the row state for a given row index.

Top module: `tx_footprint_tracker`

## Requirements
- R1: After reset every valid, transactional-read, transactional-dirty and extension bit is 0, and neither reject nor abort is asserted.
- R2: A load with its transactional flag set sets the read bit of the addressed row and way; a load without the flag changes nothing. An outermost-begin pulse clears all read bits, but a transactional load in that same cycle still sets its bit.
- R3: A store writeback with its transactional flag set sets the dirty bit of the addressed line; a writeback without the flag leaves the dirty bits unchanged.
- R4: Evicting a line clears its valid bit. If that line had its read bit set, the row's extension bit sets. Evicting a line that is only dirty leaves the extension bit unchanged.
- R5: While in a transaction, an exclusive XI (kind 2'd2) is rejected if it conflicts and fewer than REJ_LIMIT rejects have been counted. It conflicts if it hits a valid line with its read or dirty bit set, or if the row's extension bit is set. Each reject adds one to the count.
- R6: A demote XI (kind 2'd1) conflicts only when it hits a valid dirty line. When it conflicts it is handled as in R5; otherwise it causes neither reject nor abort.
- R7: A read-only XI (kind 2'd0) is never rejected. In a transaction it aborts when it hits a valid read-marked line or when the row's extension bit is set.
- R8: Once REJ_LIMIT rejects have been counted, the next conflicting exclusive or demote XI asserts abort instead of reject.
- R9: The reject count returns to 0 on a completed-instruction pulse, on commit and on any abort.
- R10: Commit clears every dirty bit and every extension bit and leaves the valid bits as they were.
- R11: An abort, whether self-decided or from the abort input, clears the valid bit of every dirty line, including a line written by a transactional store in the same cycle. It also clears all dirty and extension bits.
- R12: Outside a transaction no XI is rejected or aborts. An XI that is not rejected, is exclusive or read-only, and hits a valid line clears that line's valid bit. A demote XI never clears a valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_active_i | input | 1 | Core is in transactional mode |
| outer_begin_i | input | 1 | Pulse: outermost transaction begin |
| commit_i | input | 1 | Pulse: outermost transaction commits |
| abort_i | input | 1 | Pulse: abort from another cause |
| instr_done_i | input | 1 | Pulse: an instruction completed |
| ld_valid_i | input | 1 | Load executes |
| ld_tx_i | input | 1 | Load is transactional |
| ld_row_i | input | ROW_W | Load row |
| ld_way_i | input | WAY_W | Load hit way |
| st_valid_i | input | 1 | Store writeback |
| st_tx_i | input | 1 | Store is transactional |
| st_row_i | input | ROW_W | Store row |
| st_way_i | input | WAY_W | Store way |
| fill_valid_i | input | 1 | Line installed |
| fill_row_i | input | ROW_W | Fill row |
| fill_way_i | input | WAY_W | Fill way |
| ev_valid_i | input | 1 | Line evicted |
| ev_row_i | input | ROW_W | Eviction row |
| ev_way_i | input | WAY_W | Eviction way |
| xi_valid_i | input | 1 | XI present |
| xi_kind_i | input | 2 | 0 read-only, 1 demote, 2 exclusive |
| xi_row_i | input | ROW_W | XI row |
| xi_hit_i | input | 1 | XI tag matched in the row |
| xi_way_i | input | WAY_W | XI hit way |
| lk_row_i | input | ROW_W | Lookup row |
| xi_reject_o | output | 1 | Reject the present XI |
| abort_o | output | 1 | Tracker aborts the transaction |
| lk_valid_o | output | WAYS | Valid bits of lookup row |
| lk_txrd_o | output | WAYS | Read bits of lookup row |
| lk_txdirty_o | output | WAYS | Dirty bits of lookup row |
| lk_ext_o | output | 1 | Extension bit of lookup row |

## Verification
Two collisions matter most. The first is an abort in the same cycle as a transactional store writeback. The bench applies the abort input and a store to a second line of the same row in one cycle; it then expects both written lines invalid, a clean line in that row still valid, and no dirty bits left. The second is a completed instruction between reject bursts. The bench sends three rejects, one completion pulse, then a burst that must reject the full limit before the next conflicting XI aborts, which shows the count restarted.

// File: rtl/tft_pkg.sv
package tft_pkg;
  typedef enum logic [1:0] {
    XI_RDONLY = 2'd0,
    XI_DEMOTE = 2'd1,
    XI_EXCL   = 2'd2
  } xi_kind_e;
endpackage

// File: rtl/tft_row.sv
module tft_row #(
  parameter int WAYS = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WAYS-1:0] ld_set_i,
  input  logic [WAYS-1:0] st_set_i,
  input  logic [WAYS-1:0] ev_i,
  input  logic [WAYS-1:0] fill_i,
  input  logic [WAYS-1:0] xinv_i,
  input  logic            clr_rd_i,
  input  logic            clr_dirty_i,
  input  logic            abort_i,
  input  logic            clr_ext_i,
  output logic [WAYS-1:0] vld_o,
  output logic [WAYS-1:0] rd_o,
  output logic [WAYS-1:0] dirty_o,
  output logic            ext_o
);
  logic [WAYS-1:0] vld_q, rd_q, dirty_q, vld_n, rd_n, dirty_n, gone;
  logic            ext_q, ext_n;

  always_comb begin
    gone    = ev_i | fill_i | xinv_i;
    rd_n    = ((clr_rd_i ? '0 : rd_q) | ld_set_i) & ~gone;
    dirty_n = clr_dirty_i ? '0 : ((dirty_q | st_set_i) & ~gone);
    // abort drops every speculatively written line, including this cycle's store
    vld_n   = abort_i ? (vld_q & ~(dirty_q | st_set_i)) : vld_q;
    vld_n   = (vld_n & ~(ev_i | xinv_i)) | fill_i;
    ext_n   = clr_ext_i ? 1'b0 : (ext_q | (|(ev_i & rd_q)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      rd_q    <= '0;
      dirty_q <= '0;
      ext_q   <= 1'b0;
    end else begin
      vld_q   <= vld_n;
      rd_q    <= rd_n;
      dirty_q <= dirty_n;
      ext_q   <= ext_n;
    end
  end

  assign vld_o   = vld_q;
  assign rd_o    = rd_q;
  assign dirty_o = dirty_q;
  assign ext_o   = ext_q;

  assert_abort_drops_dirty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (dirty_q == '0));
  assert_abort_invalidates_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ((vld_q & $past(dirty_q)) == '0));
  assert_dirty_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_dirty_i |=> (dirty_q == '0));
  assert_ext_from_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_q) |-> $past(|(ev_i & rd_q)));
endmodule

// File: rtl/tft_xi_ctl.sv
module tft_xi_ctl
  import tft_pkg::*;
#(
  parameter int REJ_LIMIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_active_i,
  input  logic       xi_valid_i,
  input  logic [1:0] xi_kind_i,
  input  logic       hit_i,
  input  logic       hit_rd_i,
  input  logic       hit_dirty_i,
  input  logic       row_ext_i,
  input  logic       cnt_clr_i,
  output logic       reject_o,
  output logic       abort_o,
  output logic       inv_o
);
  localparam int CNT_W = $clog2(REJ_LIMIT + 1);

  xi_kind_e         kind;
  logic             conflict, live, room;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    kind = xi_kind_e'(xi_kind_i);
    unique case (kind)
      XI_EXCL:   conflict = (hit_i & (hit_rd_i | hit_dirty_i)) | row_ext_i;
      XI_DEMOTE: conflict = hit_i & hit_dirty_i;
      XI_RDONLY: conflict = (hit_i & hit_rd_i) | row_ext_i;
      default:   conflict = 1'b0;
    endcase
    live     = xi_valid_i & tx_active_i & conflict;
    room     = cnt_q < CNT_W'(REJ_LIMIT);
    reject_o = live & (kind != XI_RDONLY) & room;
    abort_o  = live & ~reject_o;
    inv_o    = xi_valid_i & hit_i & (kind != XI_DEMOTE) & ~reject_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (cnt_clr_i | abort_o) cnt_q <= '0;
    else if (reject_o)            cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_rdonly_no_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xi_valid_i && xi_kind_i == 2'd0) |-> !reject_o);
  assert_no_reject_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_i |-> (!reject_o && !abort_o));
  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(REJ_LIMIT));
  assert_cnt_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_q == '0));
  assert_reject_counts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_o && !cnt_clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/tx_footprint_tracker.sv
module tx_footprint_tracker #(
  parameter int ROWS      = 64,
  parameter int WAYS      = 6,
  parameter int REJ_LIMIT = 4,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_active_i,
  input  logic             outer_begin_i,
  input  logic             commit_i,
  input  logic             abort_i,
  input  logic             instr_done_i,
  input  logic             ld_valid_i,
  input  logic             ld_tx_i,
  input  logic [ROW_W-1:0] ld_row_i,
  input  logic [WAY_W-1:0] ld_way_i,
  input  logic             st_valid_i,
  input  logic             st_tx_i,
  input  logic [ROW_W-1:0] st_row_i,
  input  logic [WAY_W-1:0] st_way_i,
  input  logic             fill_valid_i,
  input  logic [ROW_W-1:0] fill_row_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             ev_valid_i,
  input  logic [ROW_W-1:0] ev_row_i,
  input  logic [WAY_W-1:0] ev_way_i,
  input  logic             xi_valid_i,
  input  logic [1:0]       xi_kind_i,
  input  logic [ROW_W-1:0] xi_row_i,
  input  logic             xi_hit_i,
  input  logic [WAY_W-1:0] xi_way_i,
  input  logic [ROW_W-1:0] lk_row_i,
  output logic             xi_reject_o,
  output logic             abort_o,
  output logic [WAYS-1:0]  lk_valid_o,
  output logic [WAYS-1:0]  lk_txrd_o,
  output logic [WAYS-1:0]  lk_txdirty_o,
  output logic             lk_ext_o
);
  logic [WAYS-1:0] vld_a [ROWS];
  logic [WAYS-1:0] rd_a  [ROWS];
  logic [WAYS-1:0] drt_a [ROWS];
  logic [ROWS-1:0] ext_v;

  logic [WAYS-1:0] ld_oh, st_oh, fill_oh, ev_oh, xi_oh;
  logic            abort_all, xi_inv, hit, hit_rd, hit_dirty;

  assign ld_oh   = WAYS'(1) << ld_way_i;
  assign st_oh   = WAYS'(1) << st_way_i;
  assign fill_oh = WAYS'(1) << fill_way_i;
  assign ev_oh   = WAYS'(1) << ev_way_i;
  assign xi_oh   = WAYS'(1) << xi_way_i;

  assign abort_all = abort_i | abort_o;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic ld_r, st_r, fill_r, ev_r, xi_r;
    assign ld_r   = ld_valid_i & ld_tx_i & (ld_row_i == ROW_W'(r));
    assign st_r   = st_valid_i & st_tx_i & (st_row_i == ROW_W'(r));
    assign fill_r = fill_valid_i & (fill_row_i == ROW_W'(r));
    assign ev_r   = ev_valid_i & (ev_row_i == ROW_W'(r));
    assign xi_r   = xi_inv & (xi_row_i == ROW_W'(r));

    tft_row #(.WAYS(WAYS)) u_row (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ld_set_i    (ld_r   ? ld_oh   : '0),
      .st_set_i    (st_r   ? st_oh   : '0),
      .ev_i        (ev_r   ? ev_oh   : '0),
      .fill_i      (fill_r ? fill_oh : '0),
      .xinv_i      (xi_r   ? xi_oh   : '0),
      .clr_rd_i    (outer_begin_i),
      .clr_dirty_i (commit_i | abort_all),
      .abort_i     (abort_all),
      .clr_ext_i   (commit_i | abort_all | outer_begin_i),
      .vld_o       (vld_a[r]),
      .rd_o        (rd_a[r]),
      .dirty_o     (drt_a[r]),
      .ext_o       (ext_v[r])
    );
  end

  assign hit       = xi_hit_i & (|(vld_a[xi_row_i] & xi_oh));
  assign hit_rd    = |(rd_a[xi_row_i] & xi_oh);
  assign hit_dirty = |(drt_a[xi_row_i] & xi_oh);

  tft_xi_ctl #(.REJ_LIMIT(REJ_LIMIT)) u_xi (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_active_i (tx_active_i),
    .xi_valid_i  (xi_valid_i),
    .xi_kind_i   (xi_kind_i),
    .hit_i       (hit),
    .hit_rd_i    (hit_rd),
    .hit_dirty_i (hit_dirty),
    .row_ext_i   (ext_v[xi_row_i]),
    .cnt_clr_i   (instr_done_i | commit_i | abort_i),
    .reject_o    (xi_reject_o),
    .abort_o     (abort_o),
    .inv_o       (xi_inv)
  );

  assign lk_valid_o   = vld_a[lk_row_i];
  assign lk_txrd_o    = rd_a[lk_row_i];
  assign lk_txdirty_o = drt_a[lk_row_i];
  assign lk_ext_o     = ext_v[lk_row_i];

  assert_reject_abort_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xi_reject_o && abort_o));
endmodule

// File: tb/tx_footprint_tracker_test.sv
`timescale 1ns/1ps
module tx_footprint_tracker_test;
  localparam int ROWS = 64, WAYS = 6, LIM = 4;
  localparam int RW = $clog2(ROWS), WW = $clog2(WAYS);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_active_i, outer_begin_i, commit_i, abort_i, instr_done_i;
  logic ld_valid_i, ld_tx_i, st_valid_i, st_tx_i, fill_valid_i, ev_valid_i, xi_valid_i, xi_hit_i;
  logic [RW-1:0] ld_row_i, st_row_i, fill_row_i, ev_row_i, xi_row_i, lk_row_i;
  logic [WW-1:0] ld_way_i, st_way_i, fill_way_i, ev_way_i, xi_way_i;
  logic [1:0] xi_kind_i;
  logic xi_reject_o, abort_o, lk_ext_o;
  logic [WAYS-1:0] lk_valid_o, lk_txrd_o, lk_txdirty_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tx_footprint_tracker #(.ROWS(ROWS), .WAYS(WAYS), .REJ_LIMIT(LIM)) uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    outer_begin_i = 0; commit_i = 0; abort_i = 0; instr_done_i = 0;
    ld_valid_i = 0; ld_tx_i = 0; st_valid_i = 0; st_tx_i = 0;
    fill_valid_i = 0; ev_valid_i = 0; xi_valid_i = 0; xi_hit_i = 0;
    ld_row_i = 0; st_row_i = 0; fill_row_i = 0; ev_row_i = 0; xi_row_i = 0;
    ld_way_i = 0; st_way_i = 0; fill_way_i = 0; ev_way_i = 0; xi_way_i = 0; xi_kind_i = 0;
  endtask

  task automatic cyc();
    @(posedge clk_i); #1; clr();
  endtask

  task automatic fill(int r, int w);
    fill_valid_i = 1; fill_row_i = RW'(r); fill_way_i = WW'(w); cyc();
  endtask
  task automatic load(int r, int w, bit tx, bit hold = 0);
    ld_valid_i = 1; ld_tx_i = tx; ld_row_i = RW'(r); ld_way_i = WW'(w);
    if (!hold) cyc();
  endtask
  task automatic store(int r, int w, bit tx, bit hold = 0);
    st_valid_i = 1; st_tx_i = tx; st_row_i = RW'(r); st_way_i = WW'(w);
    if (!hold) cyc();
  endtask
  task automatic evict(int r, int w);
    ev_valid_i = 1; ev_row_i = RW'(r); ev_way_i = WW'(w); cyc();
  endtask
  task automatic xi(int k, int r, int w, bit h);
    xi_valid_i = 1; xi_kind_i = 2'(k); xi_row_i = RW'(r); xi_way_i = WW'(w); xi_hit_i = h; #1;
  endtask
  task automatic peek(int r);
    lk_row_i = RW'(r); #1;
  endtask
  task automatic pulse_done();
    instr_done_i = 1; cyc();
  endtask

  task automatic t_reset();
    peek(5);
    chk("R1 valid", lk_valid_o, 0);
    chk("R1 read", lk_txrd_o, 0);
    chk("R1 dirty", lk_txdirty_o, 0);
    chk("R1 ext", lk_ext_o, 0);
    chk("R1 reject", xi_reject_o, 0);
    chk("R1 abort", abort_o, 0);
  endtask

  task automatic t_load();
    tx_active_i = 1; outer_begin_i = 1; cyc();
    fill(5, 2); fill(5, 3);
    load(5, 2, 1);
    peek(5); chk("R2 tx load sets", lk_txrd_o, 6'b000100);
    load(5, 3, 0);
    peek(5); chk("R2 plain load ignored", lk_txrd_o, 6'b000100);
    outer_begin_i = 1; load(5, 3, 1);
    peek(5); chk("R2 begin clears, same-cycle load sets", lk_txrd_o, 6'b001000);
  endtask

  task automatic t_store();
    fill(7, 1); fill(7, 0);
    store(7, 1, 1); store(7, 0, 0);
    peek(7);
    chk("R3 dirty", lk_txdirty_o, 6'b000010);
    chk("R3 valid", lk_valid_o, 6'b000011);
  endtask

  task automatic t_evict();
    fill(9, 0); load(9, 0, 1); evict(9, 0);
    peek(9);
    chk("R4 read evict ext", lk_ext_o, 1);
    chk("R4 evict invalid", lk_valid_o, 0);
    fill(10, 1); store(10, 1, 1); evict(10, 1);
    peek(10); chk("R4 dirty evict no ext", lk_ext_o, 0);
  endtask

  task automatic t_reject();
    xi(2, 5, 3, 1);
    chk("R5 excl read hit reject", xi_reject_o, 1);
    chk("R5 excl no abort", abort_o, 0);
    cyc(); pulse_done();
    xi(1, 5, 3, 1);
    chk("R6 demote on read line no reject", xi_reject_o, 0);
    chk("R6 demote on read line no abort", abort_o, 0);
    cyc();
    peek(5); chk("R12 demote keeps valid", lk_valid_o, 6'b001100);
    xi(2, 9, 0, 0);
    chk("R5 excl ext row reject", xi_reject_o, 1);
    cyc();
    xi(1, 7, 1, 1);
    chk("R6 demote dirty reject", xi_reject_o, 1);
    cyc(); pulse_done();
  endtask

  task automatic t_limit();
    for (int i = 0; i < 3; i++) begin
      xi(2, 7, 1, 1); chk("R5 reject burst1", xi_reject_o, 1); cyc();
    end
    pulse_done();
    for (int i = 0; i < LIM; i++) begin
      xi(2, 7, 1, 1); chk("R9 reject after done pulse", xi_reject_o, 1); cyc();
    end
    xi(2, 7, 1, 1);
    chk("R8 limit no reject", xi_reject_o, 0);
    chk("R8 limit abort", abort_o, 1);
    cyc();
    peek(7);
    chk("R11 dirty line dropped", lk_valid_o, 6'b000001);
    chk("R11 dirty cleared", lk_txdirty_o, 0);
    peek(9); chk("R11 ext cleared", lk_ext_o, 0);
    peek(5); chk("R11 clean lines kept", lk_valid_o, 6'b001100);
    xi(2, 5, 3, 1);
    chk("R9 count reset by abort", xi_reject_o, 1);
    cyc(); pulse_done();
  endtask

  task automatic t_rdonly();
    outer_begin_i = 1; cyc();
    xi(0, 5, 2, 1);
    chk("R7 ro no conflict no abort", abort_o, 0);
    cyc();
    peek(5); chk("R12 ro accepted invalidates", lk_valid_o, 6'b001000);
    fill(12, 4); load(12, 4, 1);
    xi(0, 12, 4, 1);
    chk("R7 ro read hit not rejected", xi_reject_o, 0);
    chk("R7 ro read hit abort", abort_o, 1);
    cyc();
    peek(12); chk("R12 ro hit line invalid", lk_valid_o, 0);
    outer_begin_i = 1; cyc();
    fill(13, 0); load(13, 0, 1); evict(13, 0);
    xi(0, 13, 0, 0);
    chk("R7 ro ext row abort", abort_o, 1);
    chk("R7 ro ext row no reject", xi_reject_o, 0);
    cyc();
  endtask

  // abort and a transactional store writeback in one cycle
  task automatic t_abort_store();
    outer_begin_i = 1; cyc();
    fill(20, 0); fill(20, 1); fill(20, 2);
    store(20, 0, 1);
    abort_i = 1; store(20, 1, 1);
    peek(20);
    chk("R11 abort with store valid", lk_valid_o, 6'b000100);
    chk("R11 abort with store dirty", lk_txdirty_o, 0);
  endtask

  task automatic t_commit();
    outer_begin_i = 1; cyc();
    fill(30, 0); store(30, 0, 1);
    fill(31, 0); load(31, 0, 1); evict(31, 0);
    peek(31); chk("R4 ext before commit", lk_ext_o, 1);
    commit_i = 1; cyc();
    peek(30);
    chk("R10 commit keeps valid", lk_valid_o, 6'b000001);
    chk("R10 commit clears dirty", lk_txdirty_o, 0);
    peek(31); chk("R10 commit clears ext", lk_ext_o, 0);
    xi(2, 31, 0, 0);
    chk("R10 no reject after commit", xi_reject_o, 0);
    cyc();
  endtask

  task automatic t_notx();
    tx_active_i = 0;
    fill(40, 0); fill(40, 1);
    load(40, 0, 1); store(40, 1, 1);
    xi(2, 40, 0, 1);
    chk("R12 idle excl no reject", xi_reject_o, 0);
    chk("R12 idle excl no abort", abort_o, 0);
    cyc();
    peek(40); chk("R12 idle excl invalidates", lk_valid_o, 6'b000010);
    xi(1, 40, 1, 1);
    chk("R12 idle demote no reject", xi_reject_o, 0);
    cyc();
    peek(40); chk("R12 demote keeps valid", lk_valid_o, 6'b000010);
  endtask

  initial begin
    clr(); tx_active_i = 0; lk_row_i = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    cyc();
    t_reset();
    t_load();
    t_store();
    t_evict();
    t_reject();
    t_limit();
    t_rdonly();
    t_abort_store();
    t_commit();
    t_notx();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule